// File: doc/BRIEF.md
# Token-Coupled Coprocessor Link

This block joins the issue side of a core pipeline to a coprocessor pipeline without a central stall controller. The core's issue stage pushes one token into a four-entry queue each time it hands a coprocessor operation onward. The token holds a 3-bit class code, a 4-bit sequence tag, a 4-bit word-count field and a 4-bit base register index. The coprocessor's decode stage may move an operation forward only by taking the token at the head of that queue, and only when its execute stage is free. Stages that sit behind no queue advance as soon as they are able.

Decode sorts each token by class into one of three kinds of work. It either accepts the operation or refuses it. An accepted operation runs in the execute stage as a train of data beats, one per cycle, against a local register file. Beats leave the coprocessor on outward classes and enter it on inward classes. When the operation completes, a response token carrying the tag and a refusal flag goes back through a second four-entry queue to the core's retire stage. A refused operation still takes its token and still returns a response, so the two pipelines never lose step. Every consumed token is also checked against the tag the coprocessor expects next.

Top module: `cpif_token_link`

## Requirements
- R1: A token is queued in each cycle in which `iss_valid` and `iss_ready` are both high at the clock edge. `iss_ready` is low exactly while the issue queue holds DEPTH (default 4) tokens, and no token is lost or duplicated.
- R2: The coprocessor takes one token from the issue queue only when its execute stage is idle. Operations execute and retire in issue order. Each consumed token yields exactly one response, which carries the tag that was issued with it.
- R3: Class codes and their beats: 0 = internal processing with no beats. 1 = single word out. 2 = single word in. 3 = word pair out (2 beats). 4 = word pair in (2 beats). 5 = vector out (count+1 beats). 6 = vector in (count+1 beats). 7 = reserved. `bt_out` is 1 for outward beats and 0 for inward beats.
- R4: A class whose bit in SUPPORT is clear is refused. The default SUPPORT is 8'h7D, which refuses classes 1 and 7. A refused operation produces no beats, still consumes its token, and retires with `ret_undef`=1. Accepted operations retire with `ret_undef`=0.
- R5: The beats of one operation appear in consecutive cycles. Beat i addresses register (base+i) mod 16, and `bt_last` is high on the final beat only. A vector with count 15 gives 16 beats.
- R6: An outward beat presents on `bt_data` the current content of the addressed register. An inward beat writes `bt_wdata` into the addressed register at the clock edge. All registers read 0 after reset.
- R7: The expected tag is 0 after reset and advances by one for every consumed token. `err_tag` is high for exactly one cycle, the cycle after a token whose tag differs from the expected tag is consumed, and it is low at all other times.
- R8: The response queue holds DEPTH tokens and is popped when `ret_valid` and `ret_ready` are both high. With `ret_ready` held low from an empty state, exactly 2*DEPTH+1 operations (9 by default) are accepted before `iss_ready` stays low.
- R9: During and just after reset, `iss_ready`=1, `bt_valid`=0, `ret_valid`=0 and `err_tag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue stage offers an operation |
| iss_ready | output | 1 | Issue queue has room |
| iss_cls | input | 3 | Class code of the operation |
| iss_tag | input | 4 | Sequence tag of the operation |
| iss_cnt | input | 4 | Vector word count minus one |
| iss_base | input | 4 | First coprocessor register index |
| bt_valid | output | 1 | A data beat is active |
| bt_out | output | 1 | 1: word leaves the coprocessor, 0: word enters it |
| bt_last | output | 1 | Final beat of the operation |
| bt_data | output | DATA_W | Outgoing word |
| bt_wdata | input | DATA_W | Incoming word, taken on inward beats |
| ret_valid | output | 1 | Response token available to the retire stage |
| ret_ready | input | 1 | Retire stage takes the response |
| ret_tag | output | 4 | Tag of the retiring operation |
| ret_undef | output | 1 | Operation was refused (undefined) |
| err_tag | output | 1 | Tag mismatch pulse |

## Verification
Both queues can see a push and a pop in the same cycle. An issue can land while the coprocessor takes the head token, and the execute stage can post a response while the retire stage drains one. The stimulus provokes this by keeping the queues partly filled: issue gaps are random, `ret_ready` is a random 50% pattern, and operations are fed back to back. A lost or doubled token during such a cycle would shift every later beat and response. The bench therefore judges every beat's direction, last flag and data, and every response tag and refusal flag, against its own in-order model. At the end it also requires the retire count to equal the issue count.

// File: rtl/cpif_pkg.sv
package cpif_pkg;
    localparam int CLS_W = 3;
    localparam int TAG_W = 4;
    localparam int CNT_W = 4;
    localparam int REG_W = 4;
    localparam int NREG  = 1 << REG_W;

    typedef enum logic [CLS_W-1:0] {
        OP_PROC = 3'd0,
        OP_RD1  = 3'd1,
        OP_WR1  = 3'd2,
        OP_RD2  = 3'd3,
        OP_WR2  = 3'd4,
        OP_STV  = 3'd5,
        OP_LDV  = 3'd6,
        OP_RSV  = 3'd7
    } op_cls_e;

    typedef struct packed {
        op_cls_e            cls;
        logic [TAG_W-1:0]   tag;
        logic [CNT_W-1:0]   cnt;
        logic [REG_W-1:0]   base;
    } tok_t;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic               undef;
    } rsp_t;

    typedef enum logic [1:0] {
        EX_IDLE = 2'd0,
        EX_BEAT = 2'd1,
        EX_DONE = 2'd2
    } ex_st_e;
endpackage

// File: rtl/cpif_tok_fifo.sv
module cpif_tok_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign count = q.cnt;
    assign dout  = q.mem[q.rd];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wr] = din;
            d.wr        = ptr_next(q.wr);
        end
        if (do_pop) begin
            d.rd = ptr_next(q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cpif_cls_decode.sv
module cpif_cls_decode
    import cpif_pkg::*;
#(
    parameter logic [(1<<CLS_W)-1:0] SUPPORT = 8'h7D
) (
    input  op_cls_e          cls,
    input  logic [CNT_W-1:0] cnt,
    output logic             reject,
    output logic             dir_out,
    output logic [CNT_W:0]   nbeats
);
    always_comb begin
        reject  = !SUPPORT[cls];
        dir_out = 1'b0;
        nbeats  = '0;
        case (cls)
            OP_RD1: begin dir_out = 1'b1; nbeats = (CNT_W+1)'(1); end
            OP_WR1: begin dir_out = 1'b0; nbeats = (CNT_W+1)'(1); end
            OP_RD2: begin dir_out = 1'b1; nbeats = (CNT_W+1)'(2); end
            OP_WR2: begin dir_out = 1'b0; nbeats = (CNT_W+1)'(2); end
            OP_STV: begin dir_out = 1'b1; nbeats = {1'b0, cnt} + 1'b1; end
            OP_LDV: begin dir_out = 1'b0; nbeats = {1'b0, cnt} + 1'b1; end
            default: begin dir_out = 1'b0; nbeats = '0; end
        endcase
        if (reject) nbeats = '0;
    end
endmodule

// File: rtl/cpif_exec_stage.sv
module cpif_exec_stage
    import cpif_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_avail,
    input  tok_t              tok,
    input  logic              dec_reject,
    input  logic              dec_out,
    input  logic [CNT_W:0]    dec_nbeats,
    output logic              tok_pop,
    input  logic              rsp_full,
    output logic              rsp_push,
    output rsp_t              rsp,
    output logic              bt_valid,
    output logic              bt_out,
    output logic              bt_last,
    output logic [DATA_W-1:0] bt_data,
    input  logic [DATA_W-1:0] bt_wdata,
    output logic              err_tag,
    output logic              cur_reject
);
    typedef struct packed {
        ex_st_e                        st;
        logic [CNT_W-1:0]              idx;
        logic [CNT_W-1:0]              last;
        logic [REG_W-1:0]              base;
        logic                          out;
        logic                          rej;
        logic [TAG_W-1:0]              tag;
        logic [TAG_W-1:0]              exp_tag;
        logic                          err;
        logic [NREG-1:0][DATA_W-1:0]   regs;
    } ex_t;

    ex_t q, d;
    logic [REG_W-1:0] widx;

    assign widx       = q.base + REG_W'(q.idx);
    assign bt_valid   = (q.st == EX_BEAT);
    assign bt_out     = q.out;
    assign bt_last    = bt_valid && (q.idx == q.last);
    assign bt_data    = q.regs[widx];
    assign rsp        = '{tag: q.tag, undef: q.rej};
    assign err_tag    = q.err;
    assign cur_reject = q.rej;

    always_comb begin
        d        = q;
        d.err    = 1'b0;
        tok_pop  = 1'b0;
        rsp_push = 1'b0;
        case (q.st)
            EX_IDLE: begin
                if (tok_avail) begin
                    tok_pop   = 1'b1;
                    d.tag     = tok.tag;
                    d.base    = tok.base;
                    d.out     = dec_out;
                    d.rej     = dec_reject;
                    d.idx     = '0;
                    d.last    = CNT_W'(dec_nbeats - 1'b1);
                    d.err     = (tok.tag != q.exp_tag);
                    d.exp_tag = q.exp_tag + 1'b1;
                    d.st      = (dec_nbeats == '0) ? EX_DONE : EX_BEAT;
                end
            end
            EX_BEAT: begin
                if (!q.out) d.regs[widx] = bt_wdata;
                if (q.idx == q.last) d.st  = EX_DONE;
                else                 d.idx = q.idx + 1'b1;
            end
            EX_DONE: begin
                if (!rsp_full) begin
                    rsp_push = 1'b1;
                    d.st     = EX_IDLE;
                end
            end
            default: d.st = EX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cpif_token_link.sv
module cpif_token_link
    import cpif_pkg::*;
#(
    parameter int                    DATA_W  = 32,
    parameter int                    DEPTH   = 4,
    parameter logic [(1<<CLS_W)-1:0] SUPPORT = 8'h7D,
    localparam int                   CW      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [CLS_W-1:0]  iss_cls,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic [CNT_W-1:0]  iss_cnt,
    input  logic [REG_W-1:0]  iss_base,
    output logic              bt_valid,
    output logic              bt_out,
    output logic              bt_last,
    output logic [DATA_W-1:0] bt_data,
    input  logic [DATA_W-1:0] bt_wdata,
    output logic              ret_valid,
    input  logic              ret_ready,
    output logic [TAG_W-1:0]  ret_tag,
    output logic              ret_undef,
    output logic              err_tag
);
    localparam int TW = $bits(tok_t);
    localparam int RW = $bits(rsp_t);

    tok_t            tok_in, tok_head;
    logic [TW-1:0]   qa_dout;
    logic            qa_full, qa_empty, tok_pop;
    logic [CW-1:0]   qa_cnt;
    rsp_t            rsp_in, rsp_head;
    logic [RW-1:0]   qr_dout;
    logic            qr_full, qr_empty, rsp_push;
    logic [CW-1:0]   qr_cnt;
    logic            dec_reject, dec_out, ex_reject;
    logic [CNT_W:0]  dec_nbeats;

    assign tok_in    = '{cls: op_cls_e'(iss_cls), tag: iss_tag, cnt: iss_cnt, base: iss_base};
    assign tok_head  = tok_t'(qa_dout);
    assign rsp_head  = rsp_t'(qr_dout);
    assign iss_ready = !qa_full;
    assign ret_valid = !qr_empty;
    assign ret_tag   = rsp_head.tag;
    assign ret_undef = rsp_head.undef;

    cpif_tok_fifo #(.W(TW), .DEPTH(DEPTH)) issue_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(iss_valid), .din(tok_in),
        .pop(tok_pop), .dout(qa_dout),
        .full(qa_full), .empty(qa_empty), .count(qa_cnt)
    );

    cpif_cls_decode #(.SUPPORT(SUPPORT)) decode_i (
        .cls(tok_head.cls), .cnt(tok_head.cnt),
        .reject(dec_reject), .dir_out(dec_out), .nbeats(dec_nbeats)
    );

    cpif_exec_stage #(.DATA_W(DATA_W)) exec_i (
        .clk(clk), .rst_n(rst_n),
        .tok_avail(!qa_empty), .tok(tok_head),
        .dec_reject(dec_reject), .dec_out(dec_out), .dec_nbeats(dec_nbeats),
        .tok_pop(tok_pop),
        .rsp_full(qr_full), .rsp_push(rsp_push), .rsp(rsp_in),
        .bt_valid(bt_valid), .bt_out(bt_out), .bt_last(bt_last),
        .bt_data(bt_data), .bt_wdata(bt_wdata),
        .err_tag(err_tag), .cur_reject(ex_reject)
    );

    cpif_tok_fifo #(.W(RW), .DEPTH(DEPTH)) resp_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(rsp_push), .din(rsp_in),
        .pop(ret_valid && ret_ready), .dout(qr_dout),
        .full(qr_full), .empty(qr_empty), .count(qr_cnt)
    );
endmodule

// File: rtl/cpif_token_link_chk.sv
module cpif_token_link_chk #(
    parameter int  DEPTH = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] qa_cnt,
    input logic [CW-1:0] qr_cnt,
    input logic          tok_pop,
    input logic          bt_valid,
    input logic          bt_last,
    input logic          err_tag,
    input logic          ex_reject
);
    // R1: issue queue never exceeds its depth
    assert_tok_queue_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        qa_cnt <= CW'(DEPTH));

    // R1: a full issue queue that is not drained stays full
    assert_full_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (qa_cnt == CW'(DEPTH) && !tok_pop) |=> (qa_cnt == CW'(DEPTH)));

    // R8: response queue never exceeds its depth
    assert_rsp_queue_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        qr_cnt <= CW'(DEPTH));

    // R4: a refused operation never drives a beat
    assert_no_beat_on_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bt_valid |-> !ex_reject);

    // R5: the last flag only rides on a beat, and no beat follows it directly
    assert_last_on_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bt_last |-> bt_valid);
    assert_last_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bt_last |=> !bt_valid);

    // R7: a mismatch pulse only follows a token consumption
    assert_err_after_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_tag |-> $past(tok_pop));
endmodule

bind cpif_token_link cpif_token_link_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .qa_cnt(qa_cnt), .qr_cnt(qr_cnt), .tok_pop(tok_pop),
    .bt_valid(bt_valid), .bt_last(bt_last),
    .err_tag(err_tag), .ex_reject(ex_reject)
);

// File: tb/cpif_token_link_tb.sv
module cpif_token_link_tb_top;
    localparam logic [7:0] SUP = 8'h7D;
    localparam int         DEP = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        iss_valid, iss_ready;
    logic [2:0]  iss_cls;
    logic [3:0]  iss_tag, iss_cnt, iss_base;
    logic        bt_valid, bt_out, bt_last;
    logic [31:0] bt_data, bt_wdata;
    logic        ret_valid, ret_ready, ret_undef, err_tag;
    logic [3:0]  ret_tag;

    always #5 clk = ~clk;

    cpif_token_link dut_i (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_cls(iss_cls),
        .iss_tag(iss_tag), .iss_cnt(iss_cnt), .iss_base(iss_base),
        .bt_valid(bt_valid), .bt_out(bt_out), .bt_last(bt_last),
        .bt_data(bt_data), .bt_wdata(bt_wdata),
        .ret_valid(ret_valid), .ret_ready(ret_ready),
        .ret_tag(ret_tag), .ret_undef(ret_undef), .err_tag(err_tag)
    );

    int n_vec = 0, n_bad = 0;
    int is_cls[1024], is_cnt[1024], is_base[1024], is_tag[1024];
    int n_iss = 0, bp = 0, bi = 0, rp = 0, n_err = 0, seq = 0;
    int ret_mode = 0;
    bit drv_valid = 1'b0;
    bit done = 1'b0;
    int c_cls = 0, c_cnt = 0, c_base = 0, c_tag = 0;
    logic [31:0] mreg [16];

    function automatic bit f_rej(input int c);
        return !SUP[c[2:0]];
    endfunction

    function automatic int f_nb(input int c, input int n);
        if (f_rej(c)) return 0;
        case (c)
            1, 2:    return 1;
            3, 4:    return 2;
            5, 6:    return n + 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit f_out(input int c);
        return (c == 1) || (c == 3) || (c == 5);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        case (ret_mode)
            0:       ret_ready = 1'b1;
            1:       ret_ready = 1'($urandom % 2);
            default: ret_ready = 1'b0;
        endcase
        bt_wdata  = $urandom;
        iss_valid = drv_valid;
        iss_cls   = c_cls[2:0];
        iss_cnt   = c_cnt[3:0];
        iss_base  = c_base[3:0];
        iss_tag   = c_tag[3:0];
        // beat monitor: R3 direction, R5 ordering/last, R6 data
        if (bt_valid) begin
            while (bi == 0 && bp < n_iss && f_nb(is_cls[bp], is_cnt[bp]) == 0) bp++;
            if (bp >= n_iss) begin
                chk(1'b0, "R2", "beat with no pending operation", 1, 0);
            end else begin
                int nb, ix;
                nb = f_nb(is_cls[bp], is_cnt[bp]);
                ix = (is_base[bp] + bi) % 16;
                chk(bt_out == f_out(is_cls[bp]), "R3", "beat direction", bt_out, f_out(is_cls[bp]));
                chk(bt_last == (bi == nb - 1), "R5", "last flag", bt_last, (bi == nb - 1));
                if (bt_out) chk(bt_data == mreg[ix], "R6", "outward word", bt_data, mreg[ix]);
                else        mreg[ix] = bt_wdata;
                bi++;
                if (bi == nb) begin bp++; bi = 0; end
            end
        end
        // retire monitor: R2 order/tag, R4 refusal flag
        if (ret_valid && ret_ready) begin
            if (rp >= n_iss) begin
                chk(1'b0, "R2", "response with no issued operation", 1, 0);
            end else begin
                chk(ret_tag == is_tag[rp][3:0], "R2", "retire tag", ret_tag, is_tag[rp]);
                chk(ret_undef == f_rej(is_cls[rp]), "R4", "undef flag", ret_undef, f_rej(is_cls[rp]));
                rp++;
            end
        end
        if (err_tag) n_err++;
        if (iss_valid && iss_ready) begin
            is_cls[n_iss]  = c_cls;
            is_cnt[n_iss]  = c_cnt;
            is_base[n_iss] = c_base;
            is_tag[n_iss]  = c_tag;
            n_iss++;
            seq++;
            drv_valid = 1'b0;
        end
    endtask

    task automatic issue_one(input int c, input int n, input int b, input int off);
        c_cls = c; c_cnt = n; c_base = b; c_tag = (seq + off) % 16;
        drv_valid = 1'b1;
        while (drv_valid) step();
    endtask

    task automatic drain();
        int g = 0;
        while ((rp < n_iss || drv_valid) && g < 5000) begin
            step();
            g++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d retired", rp, n_iss);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int r0, e0, a0;
        r0 = $urandom(32'h5EED1);
        for (int i = 0; i < 16; i++) mreg[i] = 32'h0;
        rst_n = 1'b0; iss_valid = 1'b0; iss_cls = '0; iss_tag = '0;
        iss_cnt = '0; iss_base = '0; ret_ready = 1'b0; bt_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(iss_ready == 1'b1, "R9", "iss_ready in reset", iss_ready, 1);
        chk(bt_valid == 1'b0, "R9", "bt_valid in reset", bt_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(iss_ready == 1'b1, "R9", "iss_ready after reset", iss_ready, 1);
        chk(bt_valid == 1'b0, "R9", "bt_valid after reset", bt_valid, 0);
        chk(ret_valid == 1'b0, "R9", "ret_valid after reset", ret_valid, 0);
        chk(err_tag == 1'b0, "R9", "err_tag after reset", err_tag, 0);

        // directed: R3 every class, R5 wrap and 16-beat vector, R6 readback, R4 refusal
        ret_mode = 0;
        issue_one(6, 3, 14, 0);
        issue_one(5, 3, 14, 0);
        issue_one(4, 0, 7, 0);
        issue_one(3, 0, 7, 0);
        issue_one(2, 0, 3, 0);
        issue_one(1, 0, 3, 0);
        issue_one(7, 5, 0, 0);
        issue_one(0, 0, 0, 0);
        issue_one(6, 15, 0, 0);
        issue_one(5, 15, 0, 0);
        issue_one(5, 0, 12, 0);
        drain();
        chk(rp == n_iss, "R2", "directed retire count", rp, n_iss);

        // R7: one wrong tag, then a right one
        e0 = n_err;
        issue_one(0, 0, 0, 5);
        issue_one(0, 0, 0, 0);
        drain();
        repeat (3) step();
        chk(n_err - e0 == 1, "R7", "mismatch pulses", n_err - e0, 1);

        // random: gaps and retire backpressure overlap pushes and pops in both queues
        ret_mode = 1;
        for (int i = 0; i < 300; i++) begin
            if ($urandom % 4 == 0) step();
            issue_one($urandom % 8, $urandom % 16, $urandom % 16, 0);
        end
        drain();
        ret_mode = 0;
        for (int i = 0; i < 100; i++) issue_one($urandom % 8, $urandom % 4, $urandom % 16, 0);
        drain();
        chk(rp == n_iss, "R2", "random retire count", rp, n_iss);

        // R8 / R1: retire stalled, count acceptances until the issue side backs up
        ret_mode = 2;
        a0 = n_iss;
        for (int i = 0; i < 40; i++) begin
            if (!drv_valid) begin
                c_cls = 0; c_cnt = 0; c_base = 0; c_tag = seq % 16;
                drv_valid = 1'b1;
            end
            step();
        end
        chk(n_iss - a0 == 2 * DEP + 1, "R8", "accepted with retire stalled", n_iss - a0, 2 * DEP + 1);
        chk(iss_ready == 1'b0, "R1", "iss_ready with full queues", iss_ready, 0);
        ret_mode = 0;
        drain();
        repeat (3) step();
        chk(rp == n_iss, "R2", "final retire count", rp, n_iss);
        chk(n_err == 1, "R7", "total mismatch pulses", n_err, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule